// File: doc/BRIEF.md
# Halfword Flash Program and Erase Controller

This block is a behavioural, synthesizable model of an on-chip NOR-style flash array together with the controller in front of it. A requester issues one command at a time on a request/ready bus: a halfword read, a halfword program, or a page erase. The controller checks each program against the rules of the cell technology. Bits can only be cleared by programming, and only an erase brings a whole page back to all ones. A program is refused unless the target halfword still reads 0xFFFF, even when the new value would only clear bits. A program to an odd byte address is refused as misaligned.

While a program or erase runs, `ready_o` stays low, and the requester cannot read any location in the array. A request has to be held until `ready_o` is high. Any command that arrives during the busy period is ignored. A one-cycle `done_o` pulse marks the end of each program or erase, whether it completed or was refused. Two sticky error flags record why the last command was refused.

The erase time is set per halfword of page, so it grows with the page size. The default settings make an erase more than 100 times longer than a program. The parameters `PAGE_BYTES` and `NUM_PAGES` must be powers of two, with at least two pages.

Top module: `nor_flash_ctrl`

## Requirements
- R1: After reset, every halfword reads 0xFFFF. `ready_o` is 1, and `done_o`, `err_prog_o` and `err_align_o` are 0.
- R2: A read is accepted on a clock edge where `req_i` and `ready_o` are 1 and `we_i` and `erase_i` are 0. From the next cycle, `rdata_o` holds the halfword at byte address `addr_i` with bit 0 ignored. Otherwise `rdata_o` keeps its value.
- R3: A program is accepted with `we_i`=1 and `erase_i`=0. If the address is even and the target halfword reads 0xFFFF, `ready_o` is low for exactly `PROG_CYCLES` cycles. After that the halfword holds `wdata_i`.
- R4: If the target halfword is not 0xFFFF, the program is refused, even if it would only clear bits. `err_prog_o` is set, the halfword is left unchanged, `ready_o` stays high, and `done_o` pulses in the next cycle.
- R5: A program to an odd byte address (bit 0 = 1) is refused. `err_align_o` is set and `err_prog_o` is not. Nothing is written, `ready_o` stays high, and `done_o` pulses in the next cycle.
- R6: An erase is accepted with `erase_i`=1. It selects the page from the upper address bits, and address bit 0 may be odd. `ready_o` is low for `PAGE_BYTES/2*ERASE_STEP` cycles. After that every halfword of that page reads 0xFFFF, and the other pages are unchanged.
- R7: When `erase_i` and `we_i` are both 1, the command is an erase and `wdata_i` is not written.
- R8: While `ready_o` is low, requests of every kind are ignored. No halfword changes through them, `rdata_o` does not change, and the busy period is not extended. A read held across the busy period is served after `ready_o` returns.
- R9: The error flags are cleared when the next program or erase is accepted. Reads and busy cycles leave them unchanged.
- R10: `done_o` is high for exactly one cycle per program or erase, and only when `ready_o` is high. It is raised on the edge that ends the busy period, or on the edge after a refused program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Command request, held until accepted |
| we_i | input | 1 | 1 = program, 0 = read (when erase_i is 0) |
| erase_i | input | 1 | 1 = page erase, takes priority over we_i |
| addr_i | input | log2(PAGE_BYTES*NUM_PAGES) | Byte address |
| wdata_i | input | 16 | Program data |
| rdata_o | output | 16 | Read data, registered |
| ready_o | output | 1 | Controller idle, request accepted |
| done_o | output | 1 | One-cycle end-of-command pulse |
| err_prog_o | output | 1 | Sticky: program target was not erased |
| err_align_o | output | 1 | Sticky: program address was odd |

## Verification
The bench builds the block with 32-byte pages, four pages, a 3-cycle program and 2 cycles per erased halfword, so an erase takes 32 cycles. With these values, a full page erase, a check that other pages are left alone, and a read held across a complete busy period all fit in a few hundred cycles. The page boundary can be hit with addresses that are easy to compute by hand. The short program time still leaves several busy cycles in which the bench can try ignored commands.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_PROG, OP_ERASE} op_e;
  typedef enum logic [1:0] {CHK_OK, CHK_ALIGN, CHK_DIRTY} chk_e;
  localparam logic [15:0] ERASED_HW = 16'hFFFF;
endpackage

// File: rtl/nor_flash_decode.sv
module nor_flash_decode
  import nor_flash_pkg::*;
(
  input  logic        req_i,
  input  logic        idle_i,
  input  logic        we_i,
  input  logic        erase_i,
  input  logic        odd_i,
  input  logic [15:0] cur_word_i,
  output op_e         op_o,
  output chk_e        verdict_o
);
  always_comb begin
    op_o      = OP_IDLE;
    verdict_o = CHK_OK;
    if (req_i && idle_i) begin
      if (erase_i) begin
        op_o = OP_ERASE;
      end else if (we_i) begin
        op_o = OP_PROG;
        // alignment is judged before cell state
        if (odd_i)                         verdict_o = CHK_ALIGN;
        else if (cur_word_i != ERASED_HW)  verdict_o = CHK_DIRTY;
      end else begin
        op_o = OP_READ;
      end
    end
  end
endmodule

// File: rtl/nor_flash_timer.sv
module nor_flash_timer #(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 1024,
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_prog_i,
  input  logic start_erase_i,
  output logic busy_o,
  output logic finish_o,
  output logic erase_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             erase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_erase_i) begin
      busy_q  <= 1'b1;
      erase_q <= 1'b1;
      cnt_q   <= CNT_W'(ERASE_CYCLES - 1);
    end else if (start_prog_i) begin
      busy_q  <= 1'b1;
      erase_q <= 1'b0;
      cnt_q   <= CNT_W'(PROG_CYCLES - 1);
    end
  end

  assign busy_o   = busy_q;
  assign finish_o = busy_q && (cnt_q == '0);
  assign erase_o  = erase_q;
endmodule

// File: rtl/nor_flash_array.sv
module nor_flash_array
  import nor_flash_pkg::*;
#(
  parameter int WORDS = 2048,
  parameter int IDX_W = 11,
  parameter int OFS_W = 10,
  parameter int PG_W  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [15:0]      rdata_o,
  input  logic [IDX_W-1:0] peek_idx_i,
  output logic [15:0]      peek_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [15:0]      wr_data_i,
  input  logic             erase_en_i,
  input  logic [PG_W-1:0]  erase_page_i
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= ERASED_HW;
      rdata_o <= '0;
    end else begin
      if (rd_en_i) rdata_o <= mem[rd_idx_i];
      // programming can only pull bits low
      if (wr_en_i) mem[wr_idx_i] <= mem[wr_idx_i] & wr_data_i;
      if (erase_en_i) begin
        for (int i = 0; i < WORDS; i++)
          if (PG_W'(i >> OFS_W) == erase_page_i) mem[i] <= ERASED_HW;
      end
    end
  end

  assign peek_o = mem[peek_idx_i];
endmodule

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl
  import nor_flash_pkg::*;
#(
  parameter int PAGE_BYTES  = 2048,
  parameter int NUM_PAGES   = 2,
  parameter int PROG_CYCLES = 8,
  parameter int ERASE_STEP  = 1,
  localparam int ADDR_W = $clog2(PAGE_BYTES * NUM_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              ready_o,
  output logic              done_o,
  output logic              err_prog_o,
  output logic              err_align_o
);
  localparam int PAGE_HW      = PAGE_BYTES / 2;
  localparam int WORDS        = NUM_PAGES * PAGE_HW;
  localparam int IDX_W        = ADDR_W - 1;
  localparam int OFS_W        = $clog2(PAGE_HW);
  localparam int PG_W         = IDX_W - OFS_W;
  localparam int ERASE_CYCLES = PAGE_HW * ERASE_STEP;

  op_e              op;
  chk_e             verdict;
  logic             busy, finish, fin_erase;
  logic             start_prog, start_erase;
  logic [15:0]      cur_word;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] wr_idx_q;
  logic [15:0]      wr_data_q;
  logic [PG_W-1:0]  page_q;
  logic             done_q, err_prog_q, err_align_q;

  assign idx = addr_i[ADDR_W-1:1];

  nor_flash_decode u_dec (
    .req_i      (req_i),
    .idle_i     (!busy),
    .we_i       (we_i),
    .erase_i    (erase_i),
    .odd_i      (addr_i[0]),
    .cur_word_i (cur_word),
    .op_o       (op),
    .verdict_o  (verdict)
  );

  assign start_prog  = (op == OP_PROG) && (verdict == CHK_OK);
  assign start_erase = (op == OP_ERASE);

  nor_flash_timer #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_tmr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_prog_i  (start_prog),
    .start_erase_i (start_erase),
    .busy_o        (busy),
    .finish_o      (finish),
    .erase_o       (fin_erase)
  );

  nor_flash_array #(
    .WORDS (WORDS),
    .IDX_W (IDX_W),
    .OFS_W (OFS_W),
    .PG_W  (PG_W)
  ) u_arr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_en_i      (op == OP_READ),
    .rd_idx_i     (idx),
    .rdata_o      (rdata_o),
    .peek_idx_i   (idx),
    .peek_o       (cur_word),
    .wr_en_i      (finish && !fin_erase),
    .wr_idx_i     (wr_idx_q),
    .wr_data_i    (wr_data_q),
    .erase_en_i   (finish && fin_erase),
    .erase_page_i (page_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q    <= '0;
      wr_data_q   <= '0;
      page_q      <= '0;
      done_q      <= 1'b0;
      err_prog_q  <= 1'b0;
      err_align_q <= 1'b0;
    end else begin
      if (start_prog) begin
        wr_idx_q  <= idx;
        wr_data_q <= wdata_i;
      end
      if (start_erase) page_q <= addr_i[ADDR_W-1 -: PG_W];
      done_q <= finish || ((op == OP_PROG) && (verdict != CHK_OK));
      if (op == OP_PROG || op == OP_ERASE) begin
        err_prog_q  <= (verdict == CHK_DIRTY);
        err_align_q <= (verdict == CHK_ALIGN);
      end
    end
  end

  assign ready_o     = !busy;
  assign done_o      = done_q;
  assign err_prog_o  = err_prog_q;
  assign err_align_o = err_align_q;
endmodule

// File: rtl/nor_flash_chk.sv
module nor_flash_chk #(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 1024
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic        erase_i,
  input logic [15:0] rdata_o,
  input logic        ready_o,
  input logic        done_o,
  input logic        err_prog_o,
  input logic        err_align_o
);
  int busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_len <= 0;
    else if (!ready_o) busy_len <= busy_len + 1;
    else               busy_len <= 0;
  end

  p_busy_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (busy_len == PROG_CYCLES || busy_len == ERASE_CYCLES));

  p_refuse_dirty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_prog_o) |-> (ready_o && done_o));

  p_refuse_align_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_align_o) |-> (ready_o && done_o && !err_prog_o));

  p_erase_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && erase_i) |=> (!ready_o && !err_prog_o && !err_align_o));

  p_stall_rdata_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(rdata_o));

  p_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && ready_o && (we_i || erase_i)) |=> $stable({err_prog_o, err_align_o}));

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
endmodule

bind nor_flash_ctrl nor_flash_chk #(
  .PROG_CYCLES  (PROG_CYCLES),
  .ERASE_CYCLES (ERASE_CYCLES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .erase_i     (erase_i),
  .rdata_o     (rdata_o),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .err_prog_o  (err_prog_o),
  .err_align_o (err_align_o)
);

// File: tb/nor_flash_ctrl_tb.sv
module nor_flash_ctrl_tb;
  localparam int PB  = 32;
  localparam int NP  = 4;
  localparam int PC  = 3;
  localparam int ES  = 2;
  localparam int AW  = $clog2(PB * NP);
  localparam int PHW = PB / 2;
  localparam int NW  = PHW * NP;
  localparam int EC  = PHW * ES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic ready, done, err_prog, err_align;

  int n_tests = 0;
  int n_fail  = 0;
  bit run_cmp = 1'b0;

  always #2 clk = ~clk;

  nor_flash_ctrl #(
    .PAGE_BYTES (PB),
    .NUM_PAGES  (NP),
    .PROG_CYCLES(PC),
    .ERASE_STEP (ES)
  ) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .we_i        (we),
    .erase_i     (erase),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .ready_o     (ready),
    .done_o      (done),
    .err_prog_o  (err_prog),
    .err_align_o (err_align)
  );

  // behavioural reference model
  logic [15:0] m_mem [NW];
  bit m_busy, m_done, m_ep, m_ea, m_is_erase;
  int m_left, m_page, m_widx;
  logic [15:0] m_wdat, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ep = 0; m_ea = 0; m_left = 0; m_rd = '0;
      for (int i = 0; i < NW; i++) m_mem[i] = 16'hFFFF;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_left == 1) begin
          m_busy = 0;
          m_done = 1;
          if (m_is_erase) begin
            for (int i = 0; i < PHW; i++) m_mem[m_page * PHW + i] = 16'hFFFF;
          end else begin
            m_mem[m_widx] = m_mem[m_widx] & m_wdat;
          end
        end else begin
          m_left--;
        end
      end else if (req) begin
        if (erase) begin
          m_ep = 0; m_ea = 0;
          m_busy = 1; m_is_erase = 1; m_left = EC; m_page = int'(addr) / PB;
        end else if (we) begin
          m_ep = 0; m_ea = 0;
          if (addr[0]) begin
            m_ea = 1; m_done = 1;
          end else if (m_mem[int'(addr) / 2] != 16'hFFFF) begin
            m_ep = 1; m_done = 1;
          end else begin
            m_busy = 1; m_is_erase = 0; m_left = PC;
            m_widx = int'(addr) / 2; m_wdat = wdata;
          end
        end else begin
          m_rd = m_mem[int'(addr) / 2];
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp) begin
      check(ready == !m_busy, "R3 R6 R8 model ready", 32'(ready), 32'(!m_busy));
      check(done == m_done, "R10 model done", 32'(done), 32'(m_done));
      check(err_prog == m_ep && err_align == m_ea, "R9 model error flags",
            32'({err_prog, err_align}), 32'({m_ep, m_ea}));
      check(rdata == m_rd, "R2 model rdata", 32'(rdata), 32'(m_rd));
    end
  end

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic issue(input logic w, input logic e, input logic [AW-1:0] a, input logic [15:0] d);
    wait_ready();
    req = 1'b1; we = w; erase = e; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; erase = 1'b0;
  endtask

  task automatic run_cmd(input logic w, input logic e, input logic [AW-1:0] a, input logic [15:0] d,
                         output int busy_n, output logic done_seen);
    issue(w, e, a, d);
    busy_n = 0;
    while (!ready) begin
      busy_n++;
      @(negedge clk);
    end
    done_seen = done;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
    issue(1'b0, 1'b0, a, '0);
    v = rdata;
  endtask

  int bn;
  logic dn;
  logic [15:0] v;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ready == 1'b1, "R1 ready after reset", 32'(ready), 1);
    check(done == 1'b0 && err_prog == 1'b0 && err_align == 1'b0, "R1 flags after reset",
          32'({done, err_prog, err_align}), 0);
    rd(7'h00, v);  check(v == 16'hFFFF, "R1 first halfword erased", 32'(v), 32'hFFFF);
    rd(AW'(NW * 2 - 2), v); check(v == 16'hFFFF, "R1 last halfword erased", 32'(v), 32'hFFFF);

    // R3 program an erased halfword
    run_cmd(1'b1, 1'b0, 7'h02, 16'hA5C3, bn, dn);
    check(bn == PC, "R3 program busy cycles", 32'(bn), 32'(PC));
    check(dn == 1'b1, "R10 done after program", 32'(dn), 1);
    @(negedge clk);
    check(done == 1'b0, "R10 done single cycle", 32'(done), 0);
    rd(7'h02, v); check(v == 16'hA5C3, "R3 programmed value", 32'(v), 32'hA5C3);
    // R2 odd read address ignores bit 0
    rd(7'h03, v); check(v == 16'hA5C3, "R2 read odd address", 32'(v), 32'hA5C3);

    // R4 reprogram that only clears bits is refused
    run_cmd(1'b1, 1'b0, 7'h02, 16'h0000, bn, dn);
    check(bn == 0 && dn == 1'b1, "R4 refused without busy", 32'({bn[7:0], 7'h0, dn}), 32'h1);
    check(err_prog == 1'b1 && err_align == 1'b0, "R4 dirty flag", 32'({err_prog, err_align}), 2);
    rd(7'h02, v); check(v == 16'hA5C3, "R4 word unchanged", 32'(v), 32'hA5C3);
    check(err_prog == 1'b1, "R9 flag holds over read", 32'(err_prog), 1);

    // R5 misaligned program
    run_cmd(1'b1, 1'b0, 7'h05, 16'h1111, bn, dn);
    check(bn == 0 && dn == 1'b1, "R5 refused without busy", 32'({bn[7:0], 7'h0, dn}), 32'h1);
    check(err_align == 1'b1 && err_prog == 1'b0, "R5 align flag, R9 dirty cleared",
          32'({err_prog, err_align}), 1);
    rd(7'h04, v); check(v == 16'hFFFF, "R5 nothing written", 32'(v), 32'hFFFF);

    // R9 good program clears flags
    run_cmd(1'b1, 1'b0, 7'h06, 16'h00F0, bn, dn);
    check(err_align == 1'b0 && err_prog == 1'b0, "R9 flags cleared", 32'({err_prog, err_align}), 0);

    // R6 page erase
    run_cmd(1'b1, 1'b0, 7'h24, 16'h5A5A, bn, dn);
    run_cmd(1'b0, 1'b1, 7'h11, 16'h0000, bn, dn);
    check(bn == EC, "R6 erase busy cycles", 32'(bn), 32'(EC));
    check(dn == 1'b1, "R10 done after erase", 32'(dn), 1);
    rd(7'h02, v); check(v == 16'hFFFF, "R6 page word erased", 32'(v), 32'hFFFF);
    rd(7'h06, v); check(v == 16'hFFFF, "R6 page word erased", 32'(v), 32'hFFFF);
    rd(7'h24, v); check(v == 16'h5A5A, "R6 other page kept", 32'(v), 32'h5A5A);

    // R7 erase wins over program
    run_cmd(1'b1, 1'b1, 7'h24, 16'h0000, bn, dn);
    check(bn == EC, "R7 treated as erase", 32'(bn), 32'(EC));
    rd(7'h24, v); check(v == 16'hFFFF, "R7 no data written", 32'(v), 32'hFFFF);

    // R8 requests during busy are ignored, reads stall
    run_cmd(1'b1, 1'b0, 7'h62, 16'h1357, bn, dn);
    rd(7'h62, v); check(v == 16'h1357, "R8 setup read", 32'(v), 32'h1357);
    issue(1'b0, 1'b1, 7'h60, 16'h0000);
    bn = 0;
    for (int k = 0; k < 5; k++) begin
      req = 1'b1; we = 1'b1; addr = 7'h40; wdata = 16'h0000;
      bn++;
      @(negedge clk);
      check(rdata == 16'h1357, "R8 rdata frozen", 32'(rdata), 32'h1357);
    end
    req = 1'b1; we = 1'b0; addr = 7'h62;
    while (!ready) begin
      bn++;
      @(negedge clk);
    end
    check(bn == EC, "R8 busy not extended", 32'(bn), 32'(EC));
    check(err_prog == 1'b0 && err_align == 1'b0, "R8 ignored program sets no flag",
          32'({err_prog, err_align}), 0);
    @(negedge clk);
    req = 1'b0;
    check(rdata == 16'hFFFF, "R8 stalled read served", 32'(rdata), 32'hFFFF);
    rd(7'h40, v); check(v == 16'hFFFF, "R8 ignored program left word", 32'(v), 32'hFFFF);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule